// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Selectable Carry Source

This unit executes one integer add or subtract-from operation per accepted request on 64-bit operands. An operation adds an "A" term, either the first register operand or its bitwise inverse, to a "B" term. The B term is one of five values: the second register operand, a sign-extended 16-bit immediate, that immediate shifted up by 16 bits, all zeros or all ones. A carry-in bit is added as well. The operation picks the carry-in from four sources: a constant 0, a constant 1, the stored carry flag, or the stored overflow flag. This one adder covers plain, carrying, extended, minus-one, zero-extended, negate and alternate-carry forms.

The unit holds the arithmetic flag state itself. That state is a carry flag, a carry flag taken at the 32-bit boundary, an overflow flag and its 32-bit counterpart, a sticky summary-overflow flag, and a 4-bit condition field. Each operation class writes only the flags it is defined to write. Two request bits gate the optional updates: a record enable for the condition field and an overflow enable for the overflow flags. The result is registered and appears one clock after the request. The flags that the next operation reads as carry-in are the registered values, so back-to-back extended operations chain correctly.

Top module: `addsub_unit`

## Requirements
- R1: A request with `in_valid`=1 and a defined opcode (0 to 16) produces `out_valid`=1 with its result on `result` exactly one clock later. With `in_valid`=0, `out_valid` is 0 on the next clock and no flag changes.
- R2: The opcodes compute these sums (~a is the inverse of `src_a`, cy is the stored carry flag, ov is the stored overflow flag). 0: a+imm. 1: a+imm_hi. 2: a+b. 3: ~a+b+1. 4 and 5: a+imm. 6: ~a+imm+1. 7: a+b. 8: ~a+b+1. 9: a+b+cy. 10: ~a+b+cy. 11: a+cy-1. 12: ~a+cy-1. 13: a+cy. 14: ~a+cy. 15: ~a+1. 16: a+b+ov. All sums are taken modulo 2^64.
- R3: imm is `imm` sign-extended to 64 bits. imm_hi is `imm` placed in bits 31:16, with zeros in bits 15:0 and bit 31 copied into bits 63:32.
- R4: Opcodes 9 to 14 take the stored carry flag as carry-in. Opcode 16 takes the stored overflow flag. In both cases the flag is the value left by the previous operation.
- R5: Opcodes 4 to 14 set `cy_flag` to the carry out of bit 63 and `cy32_flag` to the carry out of bit 31.
- R6: Opcodes 0, 1, 2, 3, 15 and 16 leave `cy_flag` and `cy32_flag` unchanged.
- R7: Opcode 16 sets `ovf_flag` to the carry out of bit 63 and `ovf32_flag` to the carry out of bit 31. It leaves `sovf_flag` and `cond_flags` unchanged whatever `rc_en` and `oe_en` are.
- R8: For opcodes 2, 3 and 7 to 15 with `oe_en`=1, `ovf_flag` takes the signed overflow of the 64-bit sum and `ovf32_flag` takes the signed overflow of the low 32 bits. With `oe_en`=0, and on every other opcode except 16, both flags are unchanged.
- R9: `sovf_flag` becomes 1 when an overflow-enabled update (R8) sets `ovf_flag`. Only reset clears it.
- R10: `cond_flags` is written by opcodes 2, 3 and 7 to 15 when `rc_en`=1, and always by opcode 5. Bit 3 means the signed result is negative, bit 2 positive and nonzero, bit 1 zero. Bit 0 is `sovf_flag` as updated by the same operation. Otherwise the field is unchanged.
- R11: After reset, `out_valid`, `result` and every flag are 0.
- R12: Opcodes 17 to 31 give no valid result and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe |
| op | input | 5 | Operation code (R2) |
| src_a | input | 64 | First register operand |
| src_b | input | 64 | Second register operand |
| imm | input | 16 | Immediate operand |
| rc_en | input | 1 | Record enable for the condition field |
| oe_en | input | 1 | Overflow-flag update enable |
| out_valid | output | 1 | Result valid, one clock after the request |
| result | output | 64 | Registered sum |
| cy_flag | output | 1 | Carry out of bit 63 |
| cy32_flag | output | 1 | Carry out of bit 31 |
| ovf_flag | output | 1 | Overflow flag |
| ovf32_flag | output | 1 | 32-bit overflow flag |
| sovf_flag | output | 1 | Sticky summary overflow |
| cond_flags | output | 4 | {negative, positive, zero, summary overflow} |

## Verification
The assertions check, on every cycle, the properties that concern when a flag may change. These are the one-cycle result latency, the silence on idle cycles and on undefined opcodes, that the non-carrying classes keep the carry flags, that the alternate-carry form leaves the sticky flag and the condition field alone, that the summary overflow stays set once set, and that at most one sign bit of the condition field is high. Only the bench's scenarios can show that the values are right. That covers the sums for each carry source, the carries and signed overflows at both boundaries, immediate extension and shifting, and carry chaining across back-to-back extended operations.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_IMM         = 5'd0,
    OP_ADD_IMM_HI      = 5'd1,
    OP_ADD             = 5'd2,
    OP_SUB_FROM        = 5'd3,
    OP_ADD_IMM_CY      = 5'd4,
    OP_ADD_IMM_CY_REC  = 5'd5,
    OP_SUB_FROM_IMM_CY = 5'd6,
    OP_ADD_CY          = 5'd7,
    OP_SUB_FROM_CY     = 5'd8,
    OP_ADD_EXT         = 5'd9,
    OP_SUB_FROM_EXT    = 5'd10,
    OP_ADD_M1_EXT      = 5'd11,
    OP_SUB_FROM_M1_EXT = 5'd12,
    OP_ADD_Z_EXT       = 5'd13,
    OP_SUB_FROM_Z_EXT  = 5'd14,
    OP_NEGATE          = 5'd15,
    OP_ADD_ALT_CY      = 5'd16
  } op_e;

  typedef enum logic [2:0] {
    BSRC_REG,
    BSRC_IMM,
    BSRC_IMM_HI,
    BSRC_ZERO,
    BSRC_ONES
  } bsrc_e;

  typedef enum logic [1:0] {
    CIN_ZERO,
    CIN_ONE,
    CIN_CY,
    CIN_OVF
  } cin_e;

  typedef struct packed {
    logic  legal;
    logic  inv_a;
    bsrc_e bsrc;
    cin_e  cin;
    logic  wr_cy;
    logic  wr_alt;
    logic  oe_ok;
    logic  rc_ok;
    logic  rc_force;
  } ctl_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

endpackage

// File: rtl/addsub_decode.sv
module addsub_decode
  import addsub_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctl_t            ctl_o
);

  always_comb begin
    ctl_o       = '0;
    ctl_o.legal = 1'b1;
    ctl_o.bsrc  = BSRC_REG;
    ctl_o.cin   = CIN_ZERO;
    case (op_i)
      OP_ADD_IMM: begin
        ctl_o.bsrc = BSRC_IMM;
      end
      OP_ADD_IMM_HI: begin
        ctl_o.bsrc = BSRC_IMM_HI;
      end
      OP_ADD: begin
        ctl_o.oe_ok = 1'b1;
        ctl_o.rc_ok = 1'b1;
      end
      OP_SUB_FROM: begin
        ctl_o.inv_a = 1'b1;
        ctl_o.cin   = CIN_ONE;
        ctl_o.oe_ok = 1'b1;
        ctl_o.rc_ok = 1'b1;
      end
      OP_ADD_IMM_CY: begin
        ctl_o.bsrc  = BSRC_IMM;
        ctl_o.wr_cy = 1'b1;
      end
      OP_ADD_IMM_CY_REC: begin
        ctl_o.bsrc     = BSRC_IMM;
        ctl_o.wr_cy    = 1'b1;
        ctl_o.rc_force = 1'b1;
      end
      OP_SUB_FROM_IMM_CY: begin
        ctl_o.inv_a = 1'b1;
        ctl_o.bsrc  = BSRC_IMM;
        ctl_o.cin   = CIN_ONE;
        ctl_o.wr_cy = 1'b1;
      end
      OP_ADD_CY: begin
        ctl_o.wr_cy = 1'b1;
        ctl_o.oe_ok = 1'b1;
        ctl_o.rc_ok = 1'b1;
      end
      OP_SUB_FROM_CY: begin
        ctl_o.inv_a = 1'b1;
        ctl_o.cin   = CIN_ONE;
        ctl_o.wr_cy = 1'b1;
        ctl_o.oe_ok = 1'b1;
        ctl_o.rc_ok = 1'b1;
      end
      OP_ADD_EXT: begin
        ctl_o.cin   = CIN_CY;
        ctl_o.wr_cy = 1'b1;
        ctl_o.oe_ok = 1'b1;
        ctl_o.rc_ok = 1'b1;
      end
      OP_SUB_FROM_EXT: begin
        ctl_o.inv_a = 1'b1;
        ctl_o.cin   = CIN_CY;
        ctl_o.wr_cy = 1'b1;
        ctl_o.oe_ok = 1'b1;
        ctl_o.rc_ok = 1'b1;
      end
      OP_ADD_M1_EXT: begin
        ctl_o.bsrc  = BSRC_ONES;
        ctl_o.cin   = CIN_CY;
        ctl_o.wr_cy = 1'b1;
        ctl_o.oe_ok = 1'b1;
        ctl_o.rc_ok = 1'b1;
      end
      OP_SUB_FROM_M1_EXT: begin
        ctl_o.inv_a = 1'b1;
        ctl_o.bsrc  = BSRC_ONES;
        ctl_o.cin   = CIN_CY;
        ctl_o.wr_cy = 1'b1;
        ctl_o.oe_ok = 1'b1;
        ctl_o.rc_ok = 1'b1;
      end
      OP_ADD_Z_EXT: begin
        ctl_o.bsrc  = BSRC_ZERO;
        ctl_o.cin   = CIN_CY;
        ctl_o.wr_cy = 1'b1;
        ctl_o.oe_ok = 1'b1;
        ctl_o.rc_ok = 1'b1;
      end
      OP_SUB_FROM_Z_EXT: begin
        ctl_o.inv_a = 1'b1;
        ctl_o.bsrc  = BSRC_ZERO;
        ctl_o.cin   = CIN_CY;
        ctl_o.wr_cy = 1'b1;
        ctl_o.oe_ok = 1'b1;
        ctl_o.rc_ok = 1'b1;
      end
      OP_NEGATE: begin
        ctl_o.inv_a = 1'b1;
        ctl_o.bsrc  = BSRC_ZERO;
        ctl_o.cin   = CIN_ONE;
        ctl_o.oe_ok = 1'b1;
        ctl_o.rc_ok = 1'b1;
      end
      OP_ADD_ALT_CY: begin
        ctl_o.cin    = CIN_OVF;
        ctl_o.wr_alt = 1'b1;
      end
      default: begin
        ctl_o.legal = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/addsub_adder.sv
module addsub_adder #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              c_half_o,
  output logic              c_full_o,
  output logic              v_half_o,
  output logic              v_full_o
);

  localparam int LO_W = DATA_W / 2;
  localparam int HI_W = DATA_W - LO_W;

  logic [LO_W:0] lo_sum;
  logic [HI_W:0] hi_sum;

  // Low half first; its carry feeds the high half and is the half-boundary carry.
  assign lo_sum = {1'b0, x_i[LO_W-1:0]} + {1'b0, y_i[LO_W-1:0]} + {{LO_W{1'b0}}, cin_i};
  assign hi_sum = {1'b0, x_i[DATA_W-1:LO_W]} + {1'b0, y_i[DATA_W-1:LO_W]}
                + {{HI_W{1'b0}}, lo_sum[LO_W]};

  assign sum_o    = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
  assign c_half_o = lo_sum[LO_W];
  assign c_full_o = hi_sum[HI_W];

  // Signed overflow: like-signed addends giving an opposite-signed sum.
  assign v_half_o = (x_i[LO_W-1] == y_i[LO_W-1]) && (sum_o[LO_W-1] != x_i[LO_W-1]);
  assign v_full_o = (x_i[DATA_W-1] == y_i[DATA_W-1]) && (sum_o[DATA_W-1] != x_i[DATA_W-1]);

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  ctl_t              ctl_i,
  input  logic              rc_i,
  input  logic              oe_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic              c_half_i,
  input  logic              c_full_i,
  input  logic              v_half_i,
  input  logic              v_full_i,
  output logic              cy_o,
  output logic              cy32_o,
  output logic              ovf_o,
  output logic              ovf32_o,
  output logic              sovf_o,
  output cond_t             cond_o
);

  logic  cy_q, cy32_q, ovf_q, ovf32_q, sovf_q;
  logic  cy_d, cy32_d, ovf_d, ovf32_d, sovf_d;
  cond_t cond_q, cond_d;
  logic  rec_en;
  logic  sum_zero;

  assign rec_en   = ctl_i.rc_force || (ctl_i.rc_ok && rc_i);
  assign sum_zero = (sum_i == '0);

  always_comb begin
    cy_d    = cy_q;
    cy32_d  = cy32_q;
    ovf_d   = ovf_q;
    ovf32_d = ovf32_q;
    sovf_d  = sovf_q;
    cond_d  = cond_q;
    if (ctl_i.wr_cy) begin
      cy_d   = c_full_i;
      cy32_d = c_half_i;
    end
    if (ctl_i.wr_alt) begin
      ovf_d   = c_full_i;
      ovf32_d = c_half_i;
    end else if (ctl_i.oe_ok && oe_i) begin
      ovf_d   = v_full_i;
      ovf32_d = v_half_i;
      sovf_d  = sovf_q | v_full_i;
    end
    if (rec_en) begin
      cond_d.lt = sum_i[DATA_W-1];
      cond_d.gt = !sum_i[DATA_W-1] && !sum_zero;
      cond_d.eq = sum_zero;
      cond_d.so = sovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q    <= 1'b0;
      cy32_q  <= 1'b0;
      ovf_q   <= 1'b0;
      ovf32_q <= 1'b0;
      sovf_q  <= 1'b0;
      cond_q  <= '0;
    end else if (en_i) begin
      cy_q    <= cy_d;
      cy32_q  <= cy32_d;
      ovf_q   <= ovf_d;
      ovf32_q <= ovf32_d;
      sovf_q  <= sovf_d;
      cond_q  <= cond_d;
    end
  end

  assign cy_o    = cy_q;
  assign cy32_o  = cy32_q;
  assign ovf_o   = ovf_q;
  assign ovf32_o = ovf32_q;
  assign sovf_o  = sovf_q;
  assign cond_o  = cond_q;

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              rc_en,
  input  logic              oe_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              cy_flag,
  output logic              cy32_flag,
  output logic              ovf_flag,
  output logic              ovf32_flag,
  output logic              sovf_flag,
  output logic [3:0]        cond_flags
);

  localparam int EXT_W = DATA_W - IMM_W;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_n, rst_ok_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_ok_n   <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_ok_n   <= rst_meta_n;
    end
  end

  ctl_t ctl;
  addsub_decode u_decode (
    .op_i  (op),
    .ctl_o (ctl)
  );

  logic [DATA_W-1:0] imm_ext, imm_hi;
  assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};

  generate
    if (DATA_W > 2 * IMM_W) begin : g_hi_ext
      assign imm_hi = {{(DATA_W - 2 * IMM_W){imm[IMM_W-1]}}, imm, {IMM_W{1'b0}}};
    end else begin : g_hi_trunc
      logic [2*IMM_W-1:0] hi_wide;
      assign hi_wide = {imm, {IMM_W{1'b0}}};
      assign imm_hi  = hi_wide[DATA_W-1:0];
    end
  endgenerate

  logic [DATA_W-1:0] opnd_x, opnd_y;
  logic              cin;

  assign opnd_x = ctl.inv_a ? ~src_a : src_a;

  always_comb begin
    case (ctl.bsrc)
      BSRC_IMM:    opnd_y = imm_ext;
      BSRC_IMM_HI: opnd_y = imm_hi;
      BSRC_ZERO:   opnd_y = '0;
      BSRC_ONES:   opnd_y = '1;
      default:     opnd_y = src_b;
    endcase
  end

  logic cy_q, cy32_q, ovf_q, ovf32_q, sovf_q;
  cond_t cond_q;

  always_comb begin
    case (ctl.cin)
      CIN_ONE: cin = 1'b1;
      CIN_CY:  cin = cy_q;
      CIN_OVF: cin = ovf_q;
      default: cin = 1'b0;
    endcase
  end

  logic [DATA_W-1:0] sum;
  logic c_half, c_full, v_half, v_full;

  addsub_adder #(.DATA_W(DATA_W)) u_adder (
    .x_i      (opnd_x),
    .y_i      (opnd_y),
    .cin_i    (cin),
    .sum_o    (sum),
    .c_half_o (c_half),
    .c_full_o (c_full),
    .v_half_o (v_half),
    .v_full_o (v_full)
  );

  logic accept;
  assign accept = in_valid && ctl.legal;

  addsub_flags #(.DATA_W(DATA_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_ok_n),
    .en_i     (accept),
    .ctl_i    (ctl),
    .rc_i     (rc_en),
    .oe_i     (oe_en),
    .sum_i    (sum),
    .c_half_i (c_half),
    .c_full_i (c_full),
    .v_half_i (v_half),
    .v_full_i (v_full),
    .cy_o     (cy_q),
    .cy32_o   (cy32_q),
    .ovf_o    (ovf_q),
    .ovf32_o  (ovf32_q),
    .sovf_o   (sovf_q),
    .cond_o   (cond_q)
  );

  logic              valid_q;
  logic [DATA_W-1:0] result_q;

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      result_q <= '0;
    end else if (accept) begin
      result_q <= sum;
    end
  end

  assign out_valid  = valid_q;
  assign result     = result_q;
  assign cy_flag    = cy_q;
  assign cy32_flag  = cy32_q;
  assign ovf_flag   = ovf_q;
  assign ovf32_flag = ovf32_q;
  assign sovf_flag  = sovf_q;
  assign cond_flags = cond_q;

endmodule

// File: rtl/addsub_chk.sv
module addsub_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [4:0] op,
  input logic       rc_en,
  input logic       oe_en,
  input logic       out_valid,
  input logic       cy_flag,
  input logic       cy32_flag,
  input logic       ovf_flag,
  input logic       ovf32_flag,
  input logic       sovf_flag,
  input logic [3:0] cond_flags
);

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op <= 5'd16)) |=> out_valid);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(cy_flag) && $stable(ovf_flag)
                   && $stable(sovf_flag) && $stable(cond_flags)));

  p_undef_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op > 5'd16)) |=> (!out_valid && $stable(cy_flag) && $stable(cy32_flag)
                                    && $stable(ovf_flag) && $stable(ovf32_flag)
                                    && $stable(sovf_flag) && $stable(cond_flags)));

  p_cy_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op <= 5'd3 || op == 5'd15 || op == 5'd16))
      |=> ($stable(cy_flag) && $stable(cy32_flag)));

  p_alt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 5'd16) |=> ($stable(sovf_flag) && $stable(cond_flags)));

  p_no_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 5'd2 && !oe_en) |=> ($stable(ovf_flag) && $stable(ovf32_flag)));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sovf_flag |=> sovf_flag);

  p_no_rec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 5'd2 && !rc_en) |=> $stable(cond_flags));

  p_cond_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cond_flags[3:1]));

endmodule

bind addsub_unit addsub_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_ok_n),
  .in_valid   (in_valid),
  .op         (op),
  .rc_en      (rc_en),
  .oe_en      (oe_en),
  .out_valid  (out_valid),
  .cy_flag    (cy_flag),
  .cy32_flag  (cy32_flag),
  .ovf_flag   (ovf_flag),
  .ovf32_flag (ovf32_flag),
  .sovf_flag  (sovf_flag),
  .cond_flags (cond_flags)
);

// File: tb/tb_addsub_unit.sv
`timescale 1ns/1ps
module tb_addsub_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [4:0]  op;
  logic [63:0] src_a, src_b;
  logic [15:0] imm;
  logic        rc_en, oe_en;
  logic        out_valid;
  logic [63:0] result;
  logic        cy_flag, cy32_flag, ovf_flag, ovf32_flag, sovf_flag;
  logic [3:0]  cond_flags;

  addsub_unit dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op         (op),
    .src_a      (src_a),
    .src_b      (src_b),
    .imm        (imm),
    .rc_en      (rc_en),
    .oe_en      (oe_en),
    .out_valid  (out_valid),
    .result     (result),
    .cy_flag    (cy_flag),
    .cy32_flag  (cy32_flag),
    .ovf_flag   (ovf_flag),
    .ovf32_flag (ovf32_flag),
    .sovf_flag  (sovf_flag),
    .cond_flags (cond_flags)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Reference state, built from the requirements.
  logic        m_cy, m_cy32, m_ov, m_ov32, m_so;
  logic [3:0]  m_cond;
  logic [63:0] m_res;
  logic        m_valid;

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void model_step(input int opc, input logic [63:0] a, input logic [63:0] b,
                                     input logic [15:0] im, input logic rc, input logic oe);
    logic [63:0] x, y, s;
    logic        ci, v64, v32;
    logic [64:0] full;
    logic [32:0] lo;
    bit          ovf_class;
    m_valid = (opc <= 16);
    if (!m_valid) return;
    ovf_class = (opc == 2 || opc == 3 || (opc >= 7 && opc <= 15));
    x = (opc inside {3, 6, 8, 10, 12, 14, 15}) ? ~a : a;
    case (opc)
      0, 4, 5, 6: y = {{48{im[15]}}, im};
      1:          y = {{32{im[15]}}, im, 16'h0000};
      11, 12:     y = 64'hFFFF_FFFF_FFFF_FFFF;
      13, 14, 15: y = 64'h0;
      default:    y = b;
    endcase
    case (opc)
      3, 6, 8, 15:            ci = 1'b1;
      9, 10, 11, 12, 13, 14:  ci = m_cy;
      16:                     ci = m_ov;
      default:                ci = 1'b0;
    endcase
    full  = {1'b0, x} + {1'b0, y} + {64'h0, ci};
    lo    = {1'b0, x[31:0]} + {1'b0, y[31:0]} + {32'h0, ci};
    s     = full[63:0];
    m_res = s;
    v64 = (x[63] == y[63]) && (s[63] != x[63]);
    v32 = (x[31] == y[31]) && (s[31] != x[31]);
    if (opc >= 4 && opc <= 14) begin
      m_cy   = full[64];
      m_cy32 = lo[32];
    end
    if (opc == 16) begin
      m_ov   = full[64];
      m_ov32 = lo[32];
    end else if (oe && ovf_class) begin
      m_ov   = v64;
      m_ov32 = v32;
      m_so   = m_so | v64;
    end
    if (opc == 5 || (rc && ovf_class))
      m_cond = {s[63], !s[63] && (s != 64'h0), s == 64'h0, m_so};
  endfunction

  task automatic run_op(input int opc, input logic [63:0] a, input logic [63:0] b,
                        input logic [15:0] im, input logic rc, input logic oe);
    @(negedge clk);
    in_valid = 1'b1;
    op       = opc[4:0];
    src_a    = a;
    src_b    = b;
    imm      = im;
    rc_en    = rc;
    oe_en    = oe;
    model_step(opc, a, b, im, rc, oe);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "out_valid", {63'h0, out_valid}, {63'h0, m_valid});
    if (m_valid) chk("R2", "result", result, m_res);
    chk("R5", "cy_flag", {63'h0, cy_flag}, {63'h0, m_cy});
    chk("R5", "cy32_flag", {63'h0, cy32_flag}, {63'h0, m_cy32});
    chk("R8", "ovf_flag", {63'h0, ovf_flag}, {63'h0, m_ov});
    chk("R8", "ovf32_flag", {63'h0, ovf32_flag}, {63'h0, m_ov32});
    chk("R9", "sovf_flag", {63'h0, sovf_flag}, {63'h0, m_so});
    chk("R10", "cond_flags", {60'h0, cond_flags}, {60'h0, m_cond});
  endtask

  function automatic logic [63:0] pick_val();
    case ($urandom_range(0, 7))
      0:       return 64'h0;
      1:       return 64'hFFFF_FFFF_FFFF_FFFF;
      2:       return 64'h7FFF_FFFF_FFFF_FFFF;
      3:       return 64'h8000_0000_0000_0000;
      4:       return 64'h0000_0000_FFFF_FFFF;
      5:       return 64'h0000_0000_7FFF_FFFF;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2468));
    rst_n = 1'b0; in_valid = 1'b0; op = '0; src_a = '0; src_b = '0;
    imm = '0; rc_en = 1'b0; oe_en = 1'b0;
    m_cy = 0; m_cy32 = 0; m_ov = 0; m_ov32 = 0; m_so = 0; m_cond = '0;
    m_res = '0; m_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    chk("R11", "out_valid", {63'h0, out_valid}, 64'h0);
    chk("R11", "result", result, 64'h0);
    chk("R11", "flags", {58'h0, cy_flag, cy32_flag, ovf_flag, ovf32_flag, sovf_flag, 1'b0},
        64'h0);
    chk("R11", "cond_flags", {60'h0, cond_flags}, 64'h0);

    // R3: immediate extension and shifted placement
    run_op(1, 64'h0, 64'h0, 16'h8000, 1'b0, 1'b0);
    chk("R3", "imm_hi", result, 64'hFFFF_FFFF_8000_0000);
    run_op(0, 64'h5, 64'h0, 16'hFFFF, 1'b0, 1'b0);
    chk("R3", "imm_ext", result, 64'h4);

    // R5: carry out at both boundaries
    run_op(4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h0001, 1'b0, 1'b0);
    chk("R5", "cy pair", {62'h0, cy_flag, cy32_flag}, 64'h3);
    // R4: stored carry feeds the extended add
    run_op(9, 64'h1, 64'h2, 16'h0, 1'b0, 1'b0);
    chk("R4", "ext add", result, 64'h4);
    // R6: negate keeps carries
    run_op(4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h0001, 1'b0, 1'b0);
    run_op(15, 64'h5, 64'h0, 16'h0, 1'b1, 1'b1);
    chk("R6", "negate cy", {63'h0, cy_flag}, 64'h1);
    chk("R2", "negate", result, 64'hFFFF_FFFF_FFFF_FFFB);
    // R7: alternate carry writes carries into overflow flags
    run_op(16, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 1'b1, 1'b1);
    chk("R7", "ovf pair", {62'h0, ovf_flag, ovf32_flag}, 64'h3);
    chk("R7", "sovf", {63'h0, sovf_flag}, 64'h0);
    run_op(16, 64'h1, 64'h1, 16'h0, 1'b0, 1'b0);
    chk("R4", "alt cin", result, 64'h3);
    // R8, R9, R10: signed overflow, sticky summary, condition field
    run_op(2, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 1'b0, 1'b1);
    chk("R8", "ovf pair", {62'h0, ovf_flag, ovf32_flag}, 64'h2);
    run_op(2, 64'h1, 64'h1, 16'h0, 1'b1, 1'b1);
    chk("R9", "sticky", {62'h0, ovf_flag, sovf_flag}, 64'h1);
    chk("R10", "cond gt", {60'h0, cond_flags}, 64'h5);
    run_op(2, 64'h0, 64'h0, 16'h0, 1'b0, 1'b0);
    chk("R10", "no record", {60'h0, cond_flags}, 64'h5);
    run_op(5, 64'h0, 64'h0, 16'h0, 1'b0, 1'b0);
    chk("R10", "forced record", {60'h0, cond_flags}, 64'h3);
    // R12: undefined opcode
    run_op(20, 64'h1234, 64'h5678, 16'h1, 1'b1, 1'b1);
    chk("R12", "no valid", {63'h0, out_valid}, 64'h0);
    chk("R12", "cond kept", {60'h0, cond_flags}, 64'h3);

    // Random mix, including undefined opcodes
    for (int i = 0; i < 4000; i++) begin
      run_op(int'($urandom_range(0, 18)), pick_val(), pick_val(),
             16'($urandom()), 1'($urandom()), 1'($urandom()));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule